// File: doc/BRIEF.md
# Debounced Pitch Step Controller

This block holds the pitch step of a voice pitch shifter. The step runs from 0 to 16, and step 8 is the neutral point where the pitch does not change. Every step away from 8 shifts the pitch by a fraction of an octave, and each end of the range is about one octave from the centre. The block only produces this step value. The audio path that uses the step lies outside it.

A static mode level picks one of two front ends:

- **Stepping mode (mode low).** Three pulse buttons adjust the step. One raises it, one lowers it and one returns it to centre. Pressing raise and lower together also returns it to centre. The step stops at 0 and at 16; it does not wrap.
- **Direct mode (mode high).** A 4-bit switch code is copied into the step, so only steps 0 to 15 can be reached.

Every control input first passes through its own long-interval chatter filter. An input counts only after it has stayed high for `DEB_CYCLES` clock cycles in a row. The default of 248000 cycles is 62 ms at a 4 MHz clock. The 5-bit step output comes with a one-cycle strobe that marks each real change of the step.

Top module: `pitch_step_ctrl`

## Requirements
- R1: After the active-low reset the step is 8 and the change strobe is low; the step never leaves the range 0 to 16.
- R2: In stepping mode, each accepted raise pulse increases the step by exactly one, one clock after its filter accepts it.
- R3: In stepping mode, each accepted lower pulse decreases the step by exactly one.
- R4: A raise at step 16 leaves the step at 16, and a lower at step 0 leaves it at 0.
- R5: In stepping mode, an accepted centre pulse sets the step to 8, whatever the step was before.
- R6: If the raise and lower inputs are both accepted-high in a cycle where either one has just been accepted, the step becomes 8 and is not moved up or down.
- R7: In direct mode the step equals the filtered code (code bit 3 is the MSB, bit 0 the LSB, zero-extended to 5 bits), so the step is never 16. Raise, lower and centre pulses have no effect in direct mode.
- R8: An input that stays high for fewer than `DEB_CYCLES` cycles has no effect. A pulse held high far longer than that causes exactly one action.
- R9: The change strobe is high for exactly one cycle each time the step takes a new value. A direct-mode load of the value the step already holds gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = stepping mode, 1 = direct mode (static level) |
| up_i | input | 1 | Raw raise-pitch pulse |
| dn_i | input | 1 | Raw lower-pitch pulse |
| ctr_i | input | 1 | Raw return-to-centre pulse |
| code_i | input | 4 | Raw direct step code, bit 3 MSB |
| step_o | output | 5 | Current pitch step, 0 to 16 |
| chg_o | output | 1 | One-cycle strobe when the step changes |

## Verification
Some properties are checked on every cycle by assertions:

- The step stays within 0 to 16.
- Direct mode never produces step 16.
- The step holds at both ends.
- A centre pulse or a simultaneous raise and lower lands on 8.
- The strobe matches a change of the step.
- A filter output rises only while its raw input is high, and drops as soon as the input falls.

The bench scenarios cover what needs a whole pulse history:

- A short glitch is rejected.
- An over-long press gives exactly one action.
- A full run from centre to each end counts the right number of steps.
- Direct mode ignores the buttons.
- Entering direct mode with a code equal to the current step gives no strobe.

// File: rtl/pitch_pkg.sv
package pitch_pkg;
  localparam int STEP_W   = 5;
  localparam int CODE_W   = 4;
  localparam int STEP_MAX = 16;
  localparam int STEP_MID = 8;
  localparam int N_RAW    = 3 + CODE_W;

  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic {
    MODE_STEP = 1'b0,
    MODE_DIRECT = 1'b1
  } mode_e;

  // saturating increment toward the top of the range
  function automatic step_t step_raise(input step_t s);
    if (s >= step_t'(STEP_MAX)) return step_t'(STEP_MAX);
    return s + step_t'(1);
  endfunction

  // saturating decrement toward zero
  function automatic step_t step_lower(input step_t s);
    if (s == '0) return '0;
    return s - step_t'(1);
  endfunction

  function automatic step_t code_to_step(input logic [CODE_W-1:0] c);
    return step_t'(c);
  endfunction
endpackage

// File: rtl/pitch_deglitch.sv
module pitch_deglitch #(
  parameter int DEB_CYCLES = 248000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             clean_q;
  wire              hit_last = (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clean_q <= 1'b0;
    end else if (!raw_i) begin
      cnt_q   <= '0;
      clean_q <= 1'b0;
    end else if (!clean_q) begin
      if (hit_last) clean_q <= 1'b1;
      else          cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign clean_o = clean_q;

  // R8
  rise_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clean_o) |-> $past(raw_i));
  // R8
  drop_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_i |=> !clean_o);
endmodule

// File: rtl/pitch_inputs.sv
module pitch_inputs
  import pitch_pkg::*;
#(
  parameter int DEB_CYCLES = 248000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic              ctr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              up_db,
  output logic              dn_db,
  output logic              ctr_db,
  output logic [CODE_W-1:0] code_db
);
  logic [N_RAW-1:0] raw_vec;
  logic [N_RAW-1:0] clean_vec;

  assign raw_vec = {ctr_i, dn_i, up_i, code_i};

  for (genvar g = 0; g < N_RAW; g++) begin : g_flt
    pitch_deglitch #(.DEB_CYCLES(DEB_CYCLES)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_vec[g]),
      .clean_o(clean_vec[g])
    );
  end

  assign code_db = clean_vec[CODE_W-1:0];
  assign up_db   = clean_vec[CODE_W];
  assign dn_db   = clean_vec[CODE_W+1];
  assign ctr_db  = clean_vec[CODE_W+2];
endmodule

// File: rtl/pitch_step_core.sv
module pitch_step_core
  import pitch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              up_db,
  input  logic              dn_db,
  input  logic              ctr_db,
  input  logic [CODE_W-1:0] code_db,
  output logic [STEP_W-1:0] step_o,
  output logic              chg_o
);
  mode_e mode;
  logic  up_q, dn_q, ctr_q;
  step_t step_q, step_nxt;
  logic  chg_q;

  assign mode = mode_e'(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      ctr_q <= 1'b0;
    end else begin
      up_q  <= up_db;
      dn_q  <= dn_db;
      ctr_q <= ctr_db;
    end
  end

  // named events for the assertions
  wire up_evt   = up_db & ~up_q;
  wire dn_evt   = dn_db & ~dn_q;
  wire ctr_evt  = ctr_db & ~ctr_q;
  wire both_evt = (up_evt | dn_evt) & up_db & dn_db;
  wire step_mode = (mode == MODE_STEP);

  always_comb begin
    step_nxt = step_q;
    if (!step_mode)     step_nxt = code_to_step(code_db);
    else if (ctr_evt)   step_nxt = step_t'(STEP_MID);
    else if (both_evt)  step_nxt = step_t'(STEP_MID);
    else if (up_evt)    step_nxt = step_raise(step_q);
    else if (dn_evt)    step_nxt = step_lower(step_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= step_t'(STEP_MID);
      chg_q  <= 1'b0;
    end else begin
      step_q <= step_nxt;
      chg_q  <= (step_nxt != step_q);
    end
  end

  assign step_o = step_q;
  assign chg_o  = chg_q;

  // R1
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= step_t'(STEP_MAX));
  // R4
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && step_q == step_t'(STEP_MAX) && up_evt && !dn_db && !ctr_evt)
      |=> step_q == step_t'(STEP_MAX));
  // R4
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && step_q == '0 && dn_evt && !up_db && !ctr_evt) |=> step_q == '0);
  // R5
  centre_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && ctr_evt) |=> step_q == step_t'(STEP_MID));
  // R6
  both_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && both_evt) |=> step_q == step_t'(STEP_MID));
  // R7
  direct_no_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_mode |=> step_q != step_t'(STEP_MAX));
  // R9
  strobe_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> step_q != $past(step_q));
  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_o |-> $stable(step_q));
endmodule

// File: rtl/pitch_step_ctrl.sv
module pitch_step_ctrl
  import pitch_pkg::*;
#(
  parameter int DEB_CYCLES = 248000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_i,
  input  logic       up_i,
  input  logic       dn_i,
  input  logic       ctr_i,
  input  logic [3:0] code_i,
  output logic [4:0] step_o,
  output logic       chg_o
);
  logic              up_db, dn_db, ctr_db;
  logic [CODE_W-1:0] code_db;

  pitch_inputs #(.DEB_CYCLES(DEB_CYCLES)) u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_i   (up_i),
    .dn_i   (dn_i),
    .ctr_i  (ctr_i),
    .code_i (code_i),
    .up_db  (up_db),
    .dn_db  (dn_db),
    .ctr_db (ctr_db),
    .code_db(code_db)
  );

  pitch_step_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .up_db  (up_db),
    .dn_db  (dn_db),
    .ctr_db (ctr_db),
    .code_db(code_db),
    .step_o (step_o),
    .chg_o  (chg_o)
  );
endmodule

// File: tb/sim_pitch_step_ctrl.sv
module sim_pitch_step_ctrl;
  localparam int DEB = 20;
  localparam int LONG = DEB + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0, up_i = 1'b0, dn_i = 1'b0, ctr_i = 1'b0;
  logic [3:0] code_i = '0;
  logic [4:0] step_o;
  logic chg_o;

  int n_run = 0, n_fail = 0, chg_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pitch_step_ctrl #(.DEB_CYCLES(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .up_i(up_i), .dn_i(dn_i),
    .ctr_i(ctr_i), .code_i(code_i), .step_o(step_o), .chg_o(chg_o)
  );

  always @(negedge clk) if (rst_n && chg_o) chg_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic u, input logic d, input logic c, input int hold);
    @(negedge clk);
    up_i = u; dn_i = d; ctr_i = c;
    repeat (hold) @(negedge clk);
    up_i = 0; dn_i = 0; ctr_i = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset step", step_o, 8);
    chk("R1 reset strobe", chg_o, 0);
  endtask

  task automatic t_up();
    chg_cnt = 0;
    for (int i = 0; i < 3; i++) pulse(1, 0, 0, LONG);
    chk("R2 three raises", step_o, 11);
    chk("R9 strobes for raises", chg_cnt, 3);
  endtask

  task automatic t_down();
    for (int i = 0; i < 5; i++) pulse(0, 1, 0, LONG);
    chk("R3 five lowers", step_o, 6);
  endtask

  task automatic t_sat_top();
    chg_cnt = 0;
    for (int i = 0; i < 12; i++) pulse(1, 0, 0, LONG);
    chk("R4 top reached", step_o, 16);
    chk("R9 strobes to top", chg_cnt, 10);
    chg_cnt = 0;
    pulse(1, 0, 0, LONG);
    chk("R4 hold at top", step_o, 16);
    chk("R9 no strobe at top", chg_cnt, 0);
  endtask

  task automatic t_sat_bot();
    chg_cnt = 0;
    for (int i = 0; i < 17; i++) pulse(0, 1, 0, LONG);
    chk("R4 bottom reached", step_o, 0);
    chk("R9 strobes to bottom", chg_cnt, 16);
    pulse(0, 1, 0, LONG);
    chk("R4 hold at bottom", step_o, 0);
  endtask

  task automatic t_both();
    chg_cnt = 0;
    pulse(1, 1, 0, LONG);
    chk("R6 both to centre", step_o, 8);
    chk("R6 one strobe", chg_cnt, 1);
  endtask

  task automatic t_centre();
    pulse(1, 0, 0, LONG);
    pulse(1, 0, 0, LONG);
    chk("R2 up to 10", step_o, 10);
    pulse(0, 0, 1, LONG);
    chk("R5 centre pulse", step_o, 8);
  endtask

  task automatic t_glitch();
    chg_cnt = 0;
    pulse(1, 0, 0, DEB - 3);
    chk("R8 short raise ignored", step_o, 8);
    chk("R8 no strobe on glitch", chg_cnt, 0);
    pulse(1, 0, 0, DEB * 4);
    chk("R8 long press one step", step_o, 9);
  endtask

  task automatic t_direct();
    @(negedge clk);
    code_i = 4'b1010; mode_i = 1;
    repeat (LONG) @(negedge clk);
    chk("R7 code 10 loaded", step_o, 10);
    code_i = 4'b1111;
    repeat (LONG) @(negedge clk);
    chk("R7 code 15 loaded", step_o, 15);
    chg_cnt = 0;
    pulse(1, 0, 0, LONG);
    pulse(0, 0, 1, LONG);
    pulse(0, 1, 0, LONG);
    chk("R7 buttons ignored", step_o, 15);
    chk("R7 no strobe from buttons", chg_cnt, 0);
  endtask

  task automatic t_same();
    @(negedge clk);
    mode_i = 0;
    repeat (4) @(negedge clk);
    chk("R7 step kept on leaving direct", step_o, 15);
    chg_cnt = 0;
    @(negedge clk);
    mode_i = 1;
    repeat (6) @(negedge clk);
    chk("R9 same-value load no strobe", chg_cnt, 0);
    chk("R9 same-value step", step_o, 15);
    @(negedge clk);
    mode_i = 0; code_i = '0;
    repeat (4) @(negedge clk);
    pulse(1, 0, 0, LONG);
    chk("R2 up to 16 in stepping", step_o, 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_sat_top();
    t_sat_bot();
    t_both();
    t_centre();
    t_glitch();
    t_direct();
    t_same();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule